// File: doc/BRIEF.md
# Disk Channel Task-File Register Block

This block is the device side of a two-drive disk channel as the host sees it. It decodes byte reads and writes to an eight-entry command register window and to a small control window. It keeps one register context per drive and tracks which drive is selected. It also holds the status and error bytes, drives the channel interrupt, and carries out soft reset.

Every task-file write lands in both drive contexts, so the two drives always hold the same addressing bytes. Only the selected drive answers reads and executes commands. A few commands finish at once inside the block, and the diagnostic command resets both contexts. Codes that need data movement go to an external dispatcher through a one-cycle request pulse. The dispatcher answers with a done or an abort pulse, and the block turns that answer into the final status and an interrupt. The data port and sector storage are outside this block.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status reads 0x50 (ready 0x40 plus seek-complete 0x10) and every other task-file register reads 0x00. The interrupt is low, no dispatch request is active and drive 0 is selected.
- R2: A write to command-window offset 1 (features), 2 (sector count), 3 (sector number), 4 (cylinder low), 5 (cylinder high) or 6 (drive/head) updates the copies of both drives.
- R3: Bit 4 of a write to offset 6 selects drive 1 when set and drive 0 when clear. Reads of offsets 1 to 7 then return the selected drive's registers, with offset 1 as error and offset 7 as status.
- R4: A status read at command offset 7 clears the interrupt. A read at control offset 2 returns the same status byte and leaves the interrupt as it was.
- R5: While control-register bit 1 (interrupt disable) is set, the interrupt output holds its value. A control write with bit 1 set deasserts the interrupt if it was enabled before that write.
- R6: When control bit 2 goes from 1 to 0, both drives load these values: cylinder low and high 0x00, sector number 0x01, sector count 0x01, head 0x00, error 0x01, status 0x50. Drive 0 becomes selected.
- R7: Command codes 0x94, 0xE0 and 0xE7 complete at once, with status 0x50 and the interrupt raised. Code 0x90 loads the R6 values into both drives, selects drive 0 and leaves the interrupt unchanged.
- R8: An unknown command code, or any command to a drive whose medium input is low, aborts. The selected drive's status becomes 0x41 and its error becomes 0x04, and the interrupt is raised. The other drive is unaffected.
- R9: While the selected drive's medium input is low, command-window reads return 0x00 and a status read there does not clear the interrupt.
- R10: Codes 0x10, 0x20, 0x21, 0x30, 0x31, 0x91, 0xC4, 0xC5, 0xC6 and 0xEC produce a one-cycle dispatch pulse carrying the code and the selected drive, and status reads 0xD0 (busy 0x80 set). A done pulse then gives status 0x50, and an abort pulse gives status 0x41 with error 0x04. Either answer raises the interrupt.
- R11: Command offset 0 reads 0x00, and every control offset other than 2 reads 0x00.
- R12: A command written while a dispatched command is still pending is ignored: there is no pulse, no status change and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_rd_i | input | 1 | Byte read strobe |
| bus_ctl_i | input | 1 | 1 selects the control window, 0 the command window |
| bus_addr_i | input | 3 | Offset within the window |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| media_i | input | 2 | Medium present, one bit per drive |
| cmd_valid_o | output | 1 | One-cycle dispatch request |
| cmd_code_o | output | 8 | Dispatched command code |
| cmd_dev_o | output | 1 | Drive that the dispatched command targets |
| cmd_done_i | input | 1 | Dispatcher reports success |
| cmd_abort_i | input | 1 | Dispatcher reports failure |
| irq_o | output | 1 | Channel interrupt |

## Verification
Read data is registered, so a read strobe sampled at one rising edge shows its value on bus_rdata_o until the next edge. Register writes, command outcomes, interrupt changes and the dispatch pulse all take effect at the edge that samples the strobe or the dispatcher answer. The bench drives every input at a falling edge and compares outputs only at the following falling edge. Reads go through a queue of expected bytes that a monitor drains one cycle after each read strobe. The interrupt and dispatch outputs are checked directly, half a cycle after the edge that should change them.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int unsigned NUM_DEV = 2;
  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 3;

  localparam logic [DW-1:0] ST_BSY  = 8'h80;
  localparam logic [DW-1:0] ST_DRDY = 8'h40;
  localparam logic [DW-1:0] ST_DSC  = 8'h10;
  localparam logic [DW-1:0] ST_ERR  = 8'h01;
  localparam logic [DW-1:0] ST_IDLE = ST_DRDY | ST_DSC;
  localparam logic [DW-1:0] ST_FAIL = ST_DRDY | ST_ERR;
  localparam logic [DW-1:0] ST_WAIT = ST_BSY | ST_DRDY | ST_DSC;
  localparam logic [DW-1:0] ER_ABRT = 8'h04;
  localparam logic [DW-1:0] ER_INIT = 8'h01;

  localparam logic [AW-1:0] CTL_OFS  = 3'd2;
  localparam int unsigned   NIEN_BIT = 1;
  localparam int unsigned   SRST_BIT = 2;
  localparam int unsigned   DSEL_BIT = 4;

  typedef enum logic [AW-1:0] {
    OFS_DATA  = 3'd0, OFS_ERRF  = 3'd1, OFS_COUNT = 3'd2, OFS_SECT = 3'd3,
    OFS_CYLLO = 3'd4, OFS_CYLHI = 3'd5, OFS_DHEAD = 3'd6, OFS_STCMD = 3'd7
  } tf_ofs_e;

  typedef struct packed {
    logic [DW-1:0] feat;
    logic [DW-1:0] count;
    logic [DW-1:0] sector;
    logic [DW-1:0] cyl_lo;
    logic [DW-1:0] cyl_hi;
    logic [DW-1:0] dhead;
    logic [DW-1:0] error;
    logic [DW-1:0] status;
  } tf_regs_t;

  typedef enum logic [1:0] {CK_UNKNOWN, CK_QUICK, CK_DIAG, CK_LONG} cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [DW-1:0] code);
    case (code)
      8'h94, 8'hE0, 8'hE7:                     return CK_QUICK;
      8'h90:                                   return CK_DIAG;
      8'h10, 8'h20, 8'h21, 8'h30, 8'h31,
      8'h91, 8'hC4, 8'hC5, 8'hC6, 8'hEC:       return CK_LONG;
      default:                                 return CK_UNKNOWN;
    endcase
  endfunction
endpackage

// File: rtl/ata_tf_dev.sv
module ata_tf_dev
  import ata_tf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tf_we_i,
  input  logic [AW-1:0] tf_ofs_i,
  input  logic [DW-1:0] tf_data_i,
  input  logic          load_init_i,
  input  logic          set_ok_i,
  input  logic          set_abort_i,
  input  logic          set_busy_i,
  output tf_regs_t      regs_o
);
  tf_regs_t r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q        <= '0;
      r_q.status <= ST_IDLE;
    end else if (load_init_i) begin
      r_q.cyl_lo <= '0;
      r_q.cyl_hi <= '0;
      r_q.sector <= 8'h01;
      r_q.count  <= 8'h01;
      r_q.dhead  <= '0;
      r_q.error  <= ER_INIT;
      r_q.status <= ST_IDLE;
    end else begin
      if (tf_we_i) begin
        case (tf_ofs_e'(tf_ofs_i))
          OFS_ERRF:  r_q.feat   <= tf_data_i;
          OFS_COUNT: r_q.count  <= tf_data_i;
          OFS_SECT:  r_q.sector <= tf_data_i;
          OFS_CYLLO: r_q.cyl_lo <= tf_data_i;
          OFS_CYLHI: r_q.cyl_hi <= tf_data_i;
          OFS_DHEAD: r_q.dhead  <= tf_data_i;
          default: ;
        endcase
      end
      if (set_abort_i) begin
        r_q.status <= ST_FAIL;
        r_q.error  <= ER_ABRT;
      end else if (set_ok_i) begin
        r_q.status <= ST_IDLE;
      end else if (set_busy_i) begin
        r_q.status <= ST_WAIT;
      end
    end
  end

  assign regs_o = r_q;
endmodule

// File: rtl/ata_tf_cmd.sv
module ata_tf_cmd
  import ata_tf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] code_i,
  input  logic          sel_i,
  input  logic          media_ok_i,
  input  logic          done_i,
  input  logic          abort_i,
  input  logic          cancel_i,
  output logic          ok_o,
  output logic          abort_o,
  output logic          start_o,
  output logic          diag_o,
  output logic          ev_dev_o,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_code_o,
  output logic          cmd_dev_o
);
  logic          busy_q, valid_q, dev_q;
  logic [DW-1:0] code_q;
  cmd_kind_e     kind;

  assign kind     = classify(code_i);
  assign ev_dev_o = busy_q ? dev_q : sel_i;

  always_comb begin
    ok_o    = 1'b0;
    abort_o = 1'b0;
    start_o = 1'b0;
    diag_o  = 1'b0;
    if (cancel_i) begin
      // soft reset wins over any outcome
    end else if (busy_q) begin
      if (done_i)       ok_o    = 1'b1;
      else if (abort_i) abort_o = 1'b1;
    end else if (cmd_we_i) begin
      if (!media_ok_i) abort_o = 1'b1;
      else begin
        case (kind)
          CK_QUICK: ok_o    = 1'b1;
          CK_DIAG:  diag_o  = 1'b1;
          CK_LONG:  start_o = 1'b1;
          default:  abort_o = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      dev_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= start_o;
      if (start_o) begin
        busy_q <= 1'b1;
        dev_q  <= sel_i;
        code_q <= code_i;
      end else if (cancel_i || (busy_q && (done_i || abort_i))) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_code_o  = code_q;
  assign cmd_dev_o   = dev_q;

  // R10
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_i && !abort_i && !cancel_i |=> busy_q && !cmd_valid_o);
endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic nien_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         irq_q <= 1'b0;
    else if (!nien_i) begin
      if (set_i)         irq_q <= 1'b1;
      else if (clr_i)    irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  // R5
  masked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nien_i |=> $stable(irq_q));

  // R4
  clear_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i && !nien_i |=> !irq_q);
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic          bus_ctl_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [1:0]    media_i,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_code_o,
  output logic          cmd_dev_o,
  input  logic          cmd_done_i,
  input  logic          cmd_abort_i,
  output logic          irq_o
);
  logic          cmd_blk_wr, tf_we, cmd_we, ctl_we, srst_fall, load_init;
  logic          sel_q, nien_q, srst_q, media_ok, stat_rd;
  logic          ev_ok, ev_abort, ev_start, ev_diag, ev_dev;
  logic [DW-1:0] rd_val, rdata_q;
  tf_regs_t      regs [NUM_DEV];
  tf_regs_t      cur;

  assign cmd_blk_wr = bus_wr_i && !bus_ctl_i;
  assign tf_we      = cmd_blk_wr && bus_addr_i != OFS_DATA && bus_addr_i != OFS_STCMD;
  assign cmd_we     = cmd_blk_wr && bus_addr_i == OFS_STCMD;
  assign ctl_we     = bus_wr_i && bus_ctl_i && bus_addr_i == CTL_OFS;
  assign srst_fall  = ctl_we && srst_q && !bus_wdata_i[SRST_BIT];
  assign load_init  = srst_fall || ev_diag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      nien_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (load_init) sel_q <= 1'b0;
      else if (cmd_blk_wr && bus_addr_i == OFS_DHEAD) sel_q <= bus_wdata_i[DSEL_BIT];
      if (ctl_we) begin
        nien_q <= bus_wdata_i[NIEN_BIT];
        srst_q <= bus_wdata_i[SRST_BIT];
      end
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = (ev_dev == 1'(d));
    ata_tf_dev u_dev (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tf_we_i     (tf_we),
      .tf_ofs_i    (bus_addr_i),
      .tf_data_i   (bus_wdata_i),
      .load_init_i (load_init),
      .set_ok_i    (ev_ok && hit),
      .set_abort_i (ev_abort && hit),
      .set_busy_i  (ev_start && hit),
      .regs_o      (regs[d])
    );
  end

  assign cur      = regs[sel_q];
  assign media_ok = media_i[sel_q];

  ata_tf_cmd u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we),
    .code_i      (bus_wdata_i),
    .sel_i       (sel_q),
    .media_ok_i  (media_ok),
    .done_i      (cmd_done_i),
    .abort_i     (cmd_abort_i),
    .cancel_i    (srst_fall),
    .ok_o        (ev_ok),
    .abort_o     (ev_abort),
    .start_o     (ev_start),
    .diag_o      (ev_diag),
    .ev_dev_o    (ev_dev),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (cmd_code_o),
    .cmd_dev_o   (cmd_dev_o)
  );

  always_comb begin
    rd_val = '0;
    if (bus_ctl_i) begin
      if (bus_addr_i == CTL_OFS) rd_val = cur.status;
    end else if (media_ok) begin
      case (tf_ofs_e'(bus_addr_i))
        OFS_ERRF:  rd_val = cur.error;
        OFS_COUNT: rd_val = cur.count;
        OFS_SECT:  rd_val = cur.sector;
        OFS_CYLLO: rd_val = cur.cyl_lo;
        OFS_CYLHI: rd_val = cur.cyl_hi;
        OFS_DHEAD: rd_val = cur.dhead;
        OFS_STCMD: rd_val = cur.status;
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_val;
  end
  assign bus_rdata_o = rdata_q;

  assign stat_rd = bus_rd_i && !bus_ctl_i && bus_addr_i == OFS_STCMD && media_ok;

  ata_tf_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_ok || ev_abort),
    .clr_i  (stat_rd || (ctl_we && bus_wdata_i[NIEN_BIT])),
    .nien_i (nien_q),
    .irq_o  (irq_o)
  );

  // R3
  dev_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_blk_wr && bus_addr_i == OFS_DHEAD |=> sel_q == $past(bus_wdata_i[DSEL_BIT]));

  // R6
  soft_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_fall |=> !sel_q && regs[0].status == ST_IDLE && regs[1].error == ER_INIT);

  // R8
  abort_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_abort && !load_init |=> regs[$past(ev_dev)].status == ST_FAIL && irq_o | nien_q);
endmodule

// File: tb/ata_taskfile_test.sv
module ata_taskfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, ctl = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] media = 2'b11;
  logic       cvalid, cdev, done = 1'b0, abrt = 1'b0, irq;
  logic [7:0] ccode;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  ata_taskfile uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_ctl_i(ctl),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .media_i(media),
    .cmd_valid_o(cvalid), .cmd_code_o(ccode), .cmd_dev_o(cdev),
    .cmd_done_i(done), .cmd_abort_i(abrt), .irq_o(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic c, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; ctl = c; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic c, input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd = 1'b1; ctl = c; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(input logic ok);
    @(negedge clk);
    if (ok) done = 1'b1; else abrt = 1'b1;
    @(negedge clk);
    done = 1'b0; abrt = 1'b0;
  endtask

  // monitor: read strobe seen at an edge, data compared at the next falling edge
  initial begin
    forever begin
      logic p;
      @(posedge clk);
      p = rd;
      @(negedge clk);
      if (p && rst_n) begin
        if (exp_q.size() == 0) chk(8'hxx, 8'h00, "monitor queue empty");
        else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk({7'b0, irq}, 8'h00, "R1 irq after reset");
    chk({7'b0, cvalid}, 8'h00, "R1 no dispatch after reset");
    rd_reg(0, 3'd7, 8'h50, "R1 status reset");
    rd_reg(0, 3'd2, 8'h00, "R1 count reset");
    rd_reg(0, 3'd6, 8'h00, "R1 head reset");

    // R2 / R3: writes reach both drives
    wr_reg(0, 3'd1, 8'hAA);
    wr_reg(0, 3'd2, 8'h12);
    wr_reg(0, 3'd3, 8'h34);
    wr_reg(0, 3'd4, 8'h56);
    wr_reg(0, 3'd5, 8'h78);
    wr_reg(0, 3'd6, 8'h05);
    rd_reg(0, 3'd2, 8'h12, "R2 count drive0");
    rd_reg(0, 3'd6, 8'h05, "R2 head drive0");
    wr_reg(0, 3'd6, 8'h15);
    rd_reg(0, 3'd2, 8'h12, "R2 count drive1");
    rd_reg(0, 3'd3, 8'h34, "R2 sector drive1");
    rd_reg(0, 3'd4, 8'h56, "R2 cyl lo drive1");
    rd_reg(0, 3'd5, 8'h78, "R2 cyl hi drive1");
    rd_reg(0, 3'd6, 8'h15, "R3 head drive1");

    // R4 / R7 quick command on drive 1
    wr_reg(0, 3'd7, 8'hE7);
    chk({7'b0, irq}, 8'h01, "R7 quick raises irq");
    rd_reg(1, 3'd2, 8'h50, "R4 alt status");
    chk({7'b0, irq}, 8'h01, "R4 alt status keeps irq");
    rd_reg(0, 3'd7, 8'h50, "R4 status");
    chk({7'b0, irq}, 8'h00, "R4 status read clears irq");

    // R8 unknown code
    wr_reg(0, 3'd7, 8'h55);
    chk({7'b0, irq}, 8'h01, "R8 abort raises irq");
    rd_reg(0, 3'd7, 8'h41, "R8 abort status");
    rd_reg(0, 3'd1, 8'h04, "R8 abort error");
    wr_reg(0, 3'd6, 8'h00);
    rd_reg(0, 3'd7, 8'h50, "R8 other drive untouched");
    rd_reg(0, 3'd1, 8'h00, "R8 other drive error");

    // R5 interrupt disable
    wr_reg(1, 3'd2, 8'h02);
    wr_reg(0, 3'd7, 8'h94);
    chk({7'b0, irq}, 8'h00, "R5 masked irq held low");
    rd_reg(0, 3'd7, 8'h50, "R7 code 94 status");
    wr_reg(1, 3'd2, 8'h00);
    wr_reg(0, 3'd7, 8'hE0);
    chk({7'b0, irq}, 8'h01, "R7 code E0 raises irq");
    wr_reg(1, 3'd2, 8'h02);
    chk({7'b0, irq}, 8'h00, "R5 control write clears irq");
    wr_reg(1, 3'd2, 8'h00);

    // R10 / R12 dispatched commands
    wr_reg(0, 3'd7, 8'h20);
    chk({7'b0, cvalid}, 8'h01, "R10 dispatch pulse");
    chk(ccode, 8'h20, "R10 dispatch code");
    chk({7'b0, cdev}, 8'h00, "R10 dispatch drive");
    rd_reg(0, 3'd7, 8'hD0, "R10 busy status");
    chk({7'b0, cvalid}, 8'h00, "R10 pulse one cycle");
    wr_reg(0, 3'd7, 8'hE7);
    chk({7'b0, irq}, 8'h00, "R12 command while busy no irq");
    chk({7'b0, cvalid}, 8'h00, "R12 command while busy no pulse");
    rd_reg(0, 3'd7, 8'hD0, "R12 status unchanged");
    pulse(1'b1);
    chk({7'b0, irq}, 8'h01, "R10 done raises irq");
    rd_reg(0, 3'd7, 8'h50, "R10 done status");
    wr_reg(0, 3'd6, 8'h10);
    wr_reg(0, 3'd7, 8'hEC);
    chk(ccode, 8'hEC, "R10 second code");
    chk({7'b0, cdev}, 8'h01, "R10 second drive");
    pulse(1'b0);
    chk({7'b0, irq}, 8'h01, "R10 abort raises irq");
    rd_reg(0, 3'd7, 8'h41, "R10 abort status");
    rd_reg(0, 3'd1, 8'h04, "R10 abort error");
    chk({7'b0, irq}, 8'h00, "R4 irq cleared after abort read");

    // R6 soft reset from drive 1 selected
    wr_reg(0, 3'd4, 8'h33);
    wr_reg(1, 3'd2, 8'h04);
    wr_reg(1, 3'd2, 8'h00);
    rd_reg(0, 3'd6, 8'h00, "R6 head");
    rd_reg(0, 3'd3, 8'h01, "R6 sector");
    rd_reg(0, 3'd2, 8'h01, "R6 count");
    rd_reg(0, 3'd4, 8'h00, "R6 cyl lo");
    rd_reg(0, 3'd1, 8'h01, "R6 error");
    rd_reg(0, 3'd7, 8'h50, "R6 status");

    // R7 diagnostic
    wr_reg(0, 3'd6, 8'h1A);
    wr_reg(0, 3'd7, 8'h55);
    rd_reg(0, 3'd7, 8'h41, "R8 drive1 abort before diag");
    wr_reg(0, 3'd2, 8'h09);
    wr_reg(0, 3'd7, 8'h90);
    chk({7'b0, irq}, 8'h00, "R7 diag leaves irq");
    rd_reg(0, 3'd6, 8'h00, "R7 diag selects drive0");
    rd_reg(0, 3'd2, 8'h01, "R7 diag count");
    wr_reg(0, 3'd6, 8'h10);
    rd_reg(0, 3'd7, 8'h50, "R7 diag drive1 status");
    rd_reg(0, 3'd1, 8'h01, "R7 diag drive1 error");

    // R9 missing medium
    media = 2'b01;
    rd_reg(0, 3'd2, 8'h00, "R9 count no medium");
    wr_reg(0, 3'd7, 8'hE7);
    chk({7'b0, irq}, 8'h01, "R8 no medium aborts");
    rd_reg(1, 3'd2, 8'h41, "R8 no medium alt status");
    rd_reg(0, 3'd7, 8'h00, "R9 status no medium");
    chk({7'b0, irq}, 8'h00 | 8'h01, "R9 status read keeps irq");
    wr_reg(1, 3'd2, 8'h02);
    wr_reg(1, 3'd2, 8'h00);
    media = 2'b11;
    wr_reg(0, 3'd6, 8'h00);

    // R11
    rd_reg(0, 3'd0, 8'h00, "R11 data offset");
    rd_reg(1, 3'd0, 8'h00, "R11 control offset 0");
    rd_reg(1, 3'd5, 8'h00, "R11 control offset 5");
    rd_reg(1, 3'd2, 8'h50, "R11 control offset 2");

    repeat (3) @(negedge clk);
    chk(8'(exp_q.size()), 8'h00, "monitor drained");
    finish_run();
  end
endmodule